// File: doc/BRIEF.md
# Self-Calibrating Delay-Line TDC Back End

This block is the digital half of a time-to-digital converter built on a chain of delay cells that nobody trims or locks. Four thermometer snapshots of the chain reach it together for each hit. Two of them come from the discriminator: one on the leading edge and one on the trailing edge. The other two are taken on two consecutive rising clock edges. The two clock snapshots are one clock period apart, and that period is known. Their difference therefore says how many cells make up one period for this particular hit. The block measures that delay again on every hit and keeps no calibration from one hit to the next.

Each snapshot is cleaned of single-cell bubbles and converted to a cell count. The block then forms three raw counts:

- the period in cells;
- the arrival offset, from the first clock capture to the leading edge;
- the pulse width, from the leading edge to the trailing edge.

It divides the two time counts by the per-hit period and returns both in picoseconds with ten fractional bits. A later stage uses the width to correct time walk, so the width is reported both raw and scaled. When the calibration is not trustworthy, or the captures are out of order, the block returns an error strobe instead of a result.

Top module: `dl_tdc_backend`

## Requirements
- R1: Bit i of each capture code corresponds to cell i. A code is decoded to the index of its lowest 0 bit, or to CELLS (64) if there is no 0 bit. For example, a code of n low ones followed by zeros decodes to n.
- R2: When smoothing is enabled (the default), a lone 0 surrounded by ones, or a lone 1 surrounded by zeros, does not change the decoded count.
- R3: For a good hit, `per_cells` equals count(clock edge 2) − count(clock edge 1). `toa_cells` equals count(lead) − count(clock edge 1). `tot_cells` equals count(trail) − count(lead).
- R4: For a good hit, `toa_fx` equals floor(toa_cells × CLK_PS × 1024 / per_cells).
- R5: For a good hit, `tot_fx` equals floor(tot_cells × CLK_PS × 1024 / per_cells).
- R6: Each hit is scaled only by its own `per_cells`. A following hit with a different period gives results that depend on nothing from the earlier hit.
- R7: If `per_cells` is 0 or less than `min_cells`, the block pulses `out_err` for one cycle and keeps `out_valid` low. If `per_cells` equals `min_cells`, the hit is good.
- R8: If count(lead) < count(clock edge 1), or count(trail) < count(lead), the hit is an error in the same way as in R7.
- R9: `out_valid` or `out_err` is a one-cycle pulse. It rises exactly LAT = NUM_W + 2 clock edges after the edge that samples `hit_done`. NUM_W = 32 at the defaults, so LAT = 34.
- R10: A `hit_done` that arrives while an earlier hit is still in flight, up to and including its output edge, is ignored. It produces no second result.
- R11: While reset is held and after it is released, `out_valid` and `out_err` are low until a hit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_done | input | 1 | One-cycle strobe; the four codes are valid in this cycle |
| code_lead | input | CELLS | Line snapshot at the leading edge |
| code_trail | input | CELLS | Line snapshot at the trailing edge |
| code_clk1 | input | CELLS | Line snapshot at the first clock edge |
| code_clk2 | input | CELLS | Line snapshot at the following clock edge |
| min_cells | input | CW | Smallest acceptable period in cells |
| out_valid | output | 1 | Result strobe for a good hit |
| out_err | output | 1 | Result strobe for a rejected hit |
| per_cells | output | CW | Cells in one clock period for this hit |
| toa_cells | output | CW | Raw arrival offset in cells |
| tot_cells | output | CW | Raw pulse width in cells |
| toa_fx | output | NUM_W | Arrival time, ps with 10 fractional bits |
| tot_fx | output | NUM_W | Pulse width, ps with 10 fractional bits |

## Verification
A fault in a decoder or in the smoothing stage shows up as a raw count that is off by one or more cells, in the result strobe of the hit that met it. A divider whose remainder or quotient register is corrupted gives a wrong scaled value. A divider whose step counter is corrupted moves the strobe off its fixed cycle, and that is visible within the same hit's latency window. A busy flag or an error decision that is wrong shows up as an extra strobe, a missing strobe, or the wrong strobe, for a single hit. Each expected result carries the cycle in which it must appear, so a timing slip is caught at once.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic hit_bad(input logic [7:0] c1, input logic [7:0] c2,
                                    input logic [7:0] ld, input logic [7:0] tr,
                                    input logic [7:0] mn);
      logic bad;
      bad = (c2 <= c1) || ((c2 - c1) < mn) || (ld < c1) || (tr < ld);
      return bad;
   endfunction
endpackage

// File: rtl/tdc_therm_dec.sv
module tdc_therm_dec #(
   parameter int CELLS  = 64,
   parameter bit SMOOTH = 1'b1,
   parameter int CW     = $clog2(CELLS + 1)
) (
   input  logic [CELLS-1:0] code,
   output logic [CW-1:0]    count
);
   import tdc_pkg::*;

   logic [CELLS-1:0] sm;

   generate
      if (SMOOTH) begin : g_smooth
         logic [CELLS+1:0] ext;
         assign ext = {1'b0, code, 1'b1};
         for (genvar i = 0; i < CELLS; i++) begin : g_bit
            assign sm[i] = maj3(ext[i], ext[i+1], ext[i+2]);
         end
      end else begin : g_raw
         assign sm = code;
      end
   endgenerate

   always_comb begin
      count = CW'(CELLS);
      for (int i = CELLS - 1; i >= 0; i--) begin
         if (!sm[i]) count = CW'(i);
      end
   end
endmodule

// File: rtl/tdc_udiv.sv
module tdc_udiv #(
   parameter int NUM_W = 32,
   parameter int DEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             done
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q, den_q, rem_n;
   logic [NUM_W-1:0] q_q, q_n;
   logic [CNT_W-1:0] cnt_q;
   logic [DEN_W:0]   sh;
   logic             qbit;

   always_comb begin
      sh   = {rem_q, q_q[NUM_W-1]};
      qbit = (sh >= {1'b0, den_q});
      rem_n = qbit ? DEN_W'(sh - {1'b0, den_q}) : sh[DEN_W-1:0];
      q_n  = {q_q[NUM_W-2:0], qbit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (start) begin
         rem_q <= '0;
         den_q <= den;
         q_q   <= num;
         cnt_q <= CNT_W'(NUM_W);
         done  <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q <= rem_n;
         q_q   <= q_n;
         cnt_q <= cnt_q - 1'b1;
         done  <= (cnt_q == CNT_W'(1));
      end else begin
         done  <= 1'b0;
      end
   end

   assign quo = q_q;
endmodule

// File: rtl/dl_tdc_backend.sv
module dl_tdc_backend #(
   parameter int CELLS  = 64,
   parameter int CLK_PS = 25000,
   parameter int FRAC   = 10,
   parameter bit SMOOTH = 1'b1,
   parameter int CW     = $clog2(CELLS + 1),
   parameter int NUM_W  = CW + $clog2(CLK_PS + 1) + FRAC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_done,
   input  logic [CELLS-1:0] code_lead,
   input  logic [CELLS-1:0] code_trail,
   input  logic [CELLS-1:0] code_clk1,
   input  logic [CELLS-1:0] code_clk2,
   input  logic [CW-1:0]    min_cells,
   output logic             out_valid,
   output logic             out_err,
   output logic [CW-1:0]    per_cells,
   output logic [CW-1:0]    toa_cells,
   output logic [CW-1:0]    tot_cells,
   output logic [NUM_W-1:0] toa_fx,
   output logic [NUM_W-1:0] tot_fx
);
   import tdc_pkg::*;

   localparam int NCODE = 4;
   localparam int LAT   = NUM_W + 2;

   generate
      if (CELLS < 4 || CELLS > 255) begin : g_bad_cells
         $error("dl_tdc_backend: CELLS out of range");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("dl_tdc_backend: CLK_PS must be positive");
      end
      if (FRAC < 0 || FRAC > 16) begin : g_bad_frac
         $error("dl_tdc_backend: FRAC out of range");
      end
      if (LAT < 3) begin : g_bad_lat
         $error("dl_tdc_backend: latency too short");
      end
   endgenerate

   logic [CELLS-1:0] codes [NCODE];
   logic [CW-1:0]    cnt   [NCODE];

   assign codes[0] = code_clk1;
   assign codes[1] = code_clk2;
   assign codes[2] = code_lead;
   assign codes[3] = code_trail;

   generate
      for (genvar k = 0; k < NCODE; k++) begin : g_dec
         tdc_therm_dec #(.CELLS(CELLS), .SMOOTH(SMOOTH), .CW(CW)) u_dec (
            .code  (codes[k]),
            .count (cnt[k])
         );
      end
   endgenerate

   logic          accept;
   logic          busy_q, start_q, err_q;
   logic [CW-1:0] per_q, dtoa_q, dtot_q;
   logic          bad_now;
   logic [7:0]    c1w, c2w, ldw, trw, mnw;

   always_comb begin
      c1w = 8'(cnt[0]);
      c2w = 8'(cnt[1]);
      ldw = 8'(cnt[2]);
      trw = 8'(cnt[3]);
      mnw = 8'(min_cells);
      bad_now = hit_bad(c1w, c2w, ldw, trw, mnw);
   end

   assign accept = hit_done && !busy_q;

   logic [1:0]       div_done;
   logic [NUM_W-1:0] div_num [2];
   logic [NUM_W-1:0] div_quo [2];

   assign div_num[0] = (NUM_W'(dtoa_q) * NUM_W'(CLK_PS)) << FRAC;
   assign div_num[1] = (NUM_W'(dtot_q) * NUM_W'(CLK_PS)) << FRAC;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_div
         tdc_udiv #(.NUM_W(NUM_W), .DEN_W(CW)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start_q),
            .num   (div_num[k]),
            .den   (per_q),
            .quo   (div_quo[k]),
            .done  (div_done[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         err_q   <= 1'b0;
         per_q   <= '0;
         dtoa_q  <= '0;
         dtot_q  <= '0;
      end else begin
         start_q <= accept;
         if (accept) begin
            busy_q <= 1'b1;
            err_q  <= bad_now;
            per_q  <= cnt[1] - cnt[0];
            dtoa_q <= cnt[2] - cnt[0];
            dtot_q <= cnt[3] - cnt[2];
         end else if (div_done[0]) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         per_cells <= '0;
         toa_cells <= '0;
         tot_cells <= '0;
         toa_fx    <= '0;
         tot_fx    <= '0;
      end else begin
         out_valid <= div_done[0] && !err_q;
         out_err   <= div_done[0] && err_q;
         if (div_done[0]) begin
            per_cells <= per_q;
            toa_cells <= dtoa_q;
            tot_cells <= dtot_q;
            toa_fx    <= div_quo[0];
            tot_fx    <= div_quo[1];
         end
      end
   end
endmodule

// File: rtl/tdc_chk.sv
module tdc_chk #(
   parameter int CW     = 7,
   parameter int NUM_W  = 32,
   parameter int CLK_PS = 25000,
   parameter int FRAC   = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_err,
   input logic [CW-1:0]    min_cells,
   input logic [CW-1:0]    per_cells,
   input logic [CW-1:0]    toa_cells,
   input logic [NUM_W-1:0] toa_fx
);
   localparam logic [NUM_W-1:0] PERIOD_FX = NUM_W'(CLK_PS) << FRAC;

   // R9: one strobe at a time
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));

   // R9: strobes last one cycle
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || out_err) |=> !(out_valid || out_err));

   // R7: a good result carries a usable period
   p_cal_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (per_cells != '0) && (per_cells >= min_cells));

   // R4: an offset shorter than a period scales below one period
   p_toa_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (toa_cells < per_cells)) |-> (toa_fx < PERIOD_FX));

   // R4: zero offset scales to zero
   p_toa_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (toa_cells == '0)) |-> (toa_fx == '0));
endmodule

bind dl_tdc_backend tdc_chk #(.CW(CW), .NUM_W(NUM_W), .CLK_PS(CLK_PS), .FRAC(FRAC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_err   (out_err),
   .min_cells (min_cells),
   .per_cells (per_cells),
   .toa_cells (toa_cells),
   .toa_fx    (toa_fx)
);

// File: tb/sim_dl_tdc_backend.sv
module sim_dl_tdc_backend;
   localparam int CELLS  = 64;
   localparam int CLK_PS = 25000;
   localparam int CW     = 7;
   localparam int NUM_W  = 32;
   localparam int LAT    = NUM_W + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hit_done = 1'b0;
   logic [CELLS-1:0] code_lead = '0, code_trail = '0, code_clk1 = '0, code_clk2 = '0;
   logic [CW-1:0]    min_cells = '0;
   logic             out_valid, out_err;
   logic [CW-1:0]    per_cells, toa_cells, tot_cells;
   logic [NUM_W-1:0] toa_fx, tot_fx;

   always #10 clk = ~clk;

   dl_tdc_backend u0 (
      .clk(clk), .rst_n(rst_n), .hit_done(hit_done),
      .code_lead(code_lead), .code_trail(code_trail),
      .code_clk1(code_clk1), .code_clk2(code_clk2),
      .min_cells(min_cells), .out_valid(out_valid), .out_err(out_err),
      .per_cells(per_cells), .toa_cells(toa_cells), .tot_cells(tot_cells),
      .toa_fx(toa_fx), .tot_fx(tot_fx)
   );

   typedef struct packed {
      logic        err;
      logic [31:0] cyc;
      logic [6:0]  per;
      logic [6:0]  toa;
      logic [6:0]  tot;
      logic [31:0] toa_fx;
      logic [31:0] tot_fx;
   } exp_t;

   exp_t exp_q [$];
   int   total = 0;
   int   bad   = 0;
   int   cyc   = 0;
   bit   done  = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [CELLS-1:0] therm(input int n);
      if (n >= CELLS) return '1;
      return (64'd1 << n) - 64'd1;
   endfunction

   task automatic check(input string req, input longint act, input longint expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // drive one hit; codes given, expected from the counts they encode
   task automatic send(input logic [CELLS-1:0] k1, input logic [CELLS-1:0] k2,
                       input logic [CELLS-1:0] kl, input logic [CELLS-1:0] kt,
                       input int n1, input int n2, input int nl, input int nt);
      exp_t e;
      longint p, a, w;
      @(negedge clk);
      code_clk1 = k1; code_clk2 = k2; code_lead = kl; code_trail = kt;
      hit_done = 1'b1;
      p = n2 - n1; a = nl - n1; w = nt - nl;
      e.err = (n2 <= n1) || (p < min_cells) || (nl < n1) || (nt < nl);
      e.cyc = cyc + 1 + LAT;
      e.per = 7'(p); e.toa = 7'(a); e.tot = 7'(w);
      e.toa_fx = e.err ? 32'd0 : 32'((a * CLK_PS * 1024) / p);
      e.tot_fx = e.err ? 32'd0 : 32'((w * CLK_PS * 1024) / p);
      exp_q.push_back(e);
      @(negedge clk);
      hit_done = 1'b0;
   endtask

   task automatic hit(input int n1, input int n2, input int nl, input int nt);
      send(therm(n1), therm(n2), therm(nl), therm(nt), n1, n2, nl, nt);
      repeat (LAT + 3) @(negedge clk);
   endtask

   // monitor: pop and compare whenever a strobe shows
   always @(negedge clk) begin
      if (rst_n && (out_valid || out_err)) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected strobe", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R9 latency cycle", cyc, e.cyc);
            check("R7 R8 error strobe", out_err, e.err);
            check("R7 R8 valid strobe", out_valid, !e.err);
            if (!e.err) begin
               check("R3 per_cells", per_cells, e.per);
               check("R3 toa_cells", toa_cells, e.toa);
               check("R3 tot_cells", tot_cells, e.tot);
               check("R4 toa_fx", toa_fx, e.toa_fx);
               check("R5 tot_fx", tot_fx, e.tot_fx);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [CELLS-1:0] k;
      logic [CELLS-1:0] k2;
      repeat (3) @(negedge clk);
      check("R11 valid in reset", out_valid, 0);
      check("R11 err in reset", out_err, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 valid after reset", out_valid, 0);
      check("R11 err after reset", out_err, 0);

      // R3 R4 R5 R9 basic hit
      hit(5, 45, 15, 27);
      // R6 different period on the next hit
      hit(10, 30, 13, 29);
      hit(0, 37, 36, 36);
      // R1 all ones decodes to CELLS; zero offset
      hit(0, 64, 0, 64);
      // R2 bubbles: hole in lead at 10, stray one in clk2 zeros at 40
      k = therm(20); k[10] = 1'b0;
      k2 = therm(30); k2[40] = 1'b1;
      send(therm(3), k2, k, therm(50), 3, 30, 20, 50);
      repeat (LAT + 3) @(negedge clk);
      // R7 zero period
      hit(12, 12, 20, 30);
      // R7 below minimum, then equal to minimum
      min_cells = 7'd8;
      hit(4, 9, 5, 6);
      hit(4, 12, 5, 6);
      min_cells = 7'd0;
      // R8 lead before first clock capture, trail before lead
      hit(10, 40, 8, 20);
      hit(10, 40, 25, 20);
      // R10 second strobe while busy is ignored
      send(therm(2), therm(42), therm(22), therm(32), 2, 42, 22, 32);
      repeat (5) @(negedge clk);
      code_clk1 = therm(1); code_clk2 = therm(9); hit_done = 1'b1;
      @(negedge clk);
      hit_done = 1'b0;
      repeat (LAT + 6) @(negedge clk);
      check("R10 queue drained", exp_q.size(), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule